// File: doc/BRIEF.md
# Power-Off Request and Button Controller

This block owns the system power-off path. Two sources can request that system power be removed. The first is software, which sets a turn-off bit. The second is a power button held down past a programmable number of clock cycles. A third source is a one-cycle power-glitch pulse from an analog detector outside the block, and it counts only when software has enabled it. The result is a single active-low output, `pwr_off_n`, sent to an external power-management chip. Once that output goes low it stays low until reset.

Software sees the block through two small registers on a simple write strobe and combinational read port. A control word holds the software-power enable, the turn-off bit and the glitch-response enable. A status word shows the synchronized button level and three sticky event flags: button interrupt, power-off requested, and emergency off. The event flags are cleared by writing 1. The raw button passes through a two-flop synchronizer, and a saturating counter measures how long it has been held.

Top module: `pwr_off_ctl`

## Requirements
- R1: After reset, `pwr_off_n` is 1 and both the control word (address 0) and the status word (address 1) read 0 while the button is released.
- R2: Status bit 0 follows `btn_raw` delayed by two clock edges.
- R3: A high `btn_irq` at a clock edge sets the button-interrupt flag (status bit 1) at that edge.
- R4: Status bits 1 (button interrupt), 2 (power-off requested) and 3 (emergency off) are cleared by writing 1 to them at address 1. Writing 0 leaves a flag unchanged. A set event and a clear in the same cycle leave the flag set.
- R5: Writing control bit 1 (turn-off) as 1 while control bit 0 (software-power enable) already reads 1 sets the turn-off bit, status bits 2 and 3, and drives `pwr_off_n` low at that same edge.
- R6: A turn-off write while control bit 0 reads 0 is ignored. Control bit 1 stays 0, `pwr_off_n` stays 1, and no status flag is set.
- R7: A button press that `btn_raw` holds high at HOLD_CYCLES consecutive edges sets status bit 2 two edges after the last of those edges. It fires only once per press. If the software-power enable is 1, the same event also sets status bit 3 and drives `pwr_off_n` low.
- R8: A press held for HOLD_CYCLES-1 edges sets no flag and leaves `pwr_off_n` high.
- R9: A `glitch` pulse with control bit 2 (glitch enable) set drives `pwr_off_n` low and sets status bit 3 but not bit 2. With control bit 2 clear, the pulse has no effect.
- R10: Once low, `pwr_off_n` stays low until reset, even if the control bits are cleared and the status flags are cleared.
- R11: Addresses other than 0 and 1 read 0, and unused bits of both words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_raw | input | 1 | Asynchronous power-button level, 1 = pressed |
| btn_irq | input | 1 | Button interrupt request, sampled each edge |
| glitch | input | 1 | One-cycle power-glitch detection pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register address for both read and write |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Combinational read data for `addr` |
| pwr_off_n | output | 1 | Active-low request to remove system power |

## Verification
Two functions can land in the same cycle: a write-one-to-clear of a status flag, and the hardware event that sets that same flag. The bench forces this with a directed case where `btn_irq` is pulsed during the clearing write. It also runs a seeded random phase that mixes interrupt pulses with random status writes. A bench model recomputes the interrupt flag every cycle with set winning over clear, and the flag is compared after each edge.

// File: rtl/pwr_off_ctl.sv
module pwr_off_ctl #(
  parameter int DW          = 8,
  parameter int AW          = 2,
  parameter int HOLD_CYCLES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          btn_raw,
  input  logic          btn_irq,
  input  logic          glitch,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          pwr_off_n
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [CW-1:0] CNT_TOP = CW'(HOLD_CYCLES);
  localparam logic [CW-1:0] CNT_FIRE = CW'(HOLD_CYCLES - 1);

  logic          sync1, btn_s;
  logic [CW-1:0] hold_cnt;
  logic          sw_en_q, top_q, gl_en_q;
  logic          bi_q, spo_q, eo_q, off_q;

  wire wr_ctrl  = wr_en && (addr == A_CTRL);
  wire wr_stat  = wr_en && (addr == A_STAT);
  wire sw_req   = wr_ctrl && wr_data[1] && sw_en_q;
  wire long_evt = btn_s && (hold_cnt == CNT_FIRE);
  wire btn_req  = long_evt && sw_en_q;
  wire gl_req   = glitch && gl_en_q;
  wire off_req  = sw_req || btn_req || gl_req;

  wire unused_wr = ^wr_data[DW-1:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1    <= 1'b0;
      btn_s    <= 1'b0;
      hold_cnt <= '0;
      sw_en_q  <= 1'b0;
      top_q    <= 1'b0;
      gl_en_q  <= 1'b0;
      bi_q     <= 1'b0;
      spo_q    <= 1'b0;
      eo_q     <= 1'b0;
      off_q    <= 1'b0;
    end else begin
      sync1 <= btn_raw;
      btn_s <= sync1;
      if (!btn_s)
        hold_cnt <= '0;
      else if (hold_cnt != CNT_TOP)
        hold_cnt <= hold_cnt + 1'b1;
      if (wr_ctrl) begin
        sw_en_q <= wr_data[0];
        gl_en_q <= wr_data[2];
      end
      top_q <= top_q | sw_req;
      off_q <= off_q | off_req;
      bi_q  <= btn_irq | (bi_q & ~(wr_stat & wr_data[1]));
      spo_q <= sw_req | long_evt | (spo_q & ~(wr_stat & wr_data[2]));
      eo_q  <= off_req | (eo_q & ~(wr_stat & wr_data[3]));
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      A_CTRL: rd_data[2:0] = {gl_en_q, top_q, sw_en_q};
      A_STAT: rd_data[3:0] = {eo_q, spo_q, bi_q, btn_s};
      default: rd_data = '0;
    endcase
  end

  assign pwr_off_n = ~off_q;
endmodule

// File: rtl/pwr_off_ctl_chk.sv
module pwr_off_ctl_chk #(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_off_n,
  input logic          sw_en_q,
  input logic          gl_en_q,
  input logic          btn_irq,
  input logic          bi_q,
  input logic          spo_q,
  input logic          eo_q,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wr_data
);
  a_r10_off_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_off_n |=> !pwr_off_n);

  a_r9_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_off_n && !sw_en_q && !gl_en_q) |=> pwr_off_n);

  a_r3_irq_sets: assert property (@(posedge clk) disable iff (!rst_n)
    btn_irq |=> bi_q);

  a_r5_sw_off: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(0) && wr_data[1] && sw_en_q) |=> (!pwr_off_n && spo_q && eo_q));

  a_r9_eo_implies_off: assert property (@(posedge clk) disable iff (!rst_n)
    eo_q |-> !pwr_off_n);
endmodule

bind pwr_off_ctl pwr_off_ctl_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_off_n(pwr_off_n), .sw_en_q(sw_en_q),
  .gl_en_q(gl_en_q), .btn_irq(btn_irq), .bi_q(bi_q), .spo_q(spo_q),
  .eo_q(eo_q), .wr_en(wr_en), .addr(addr), .wr_data(wr_data)
);

// File: tb/pwr_off_ctl_bench.sv
module pwr_off_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       btn_raw = 1'b0, btn_irq = 1'b0, glitch = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       pwr_off_n;

  int tests = 0, fails = 0;
  bit done = 0;

  pwr_off_ctl #(.DW(8), .AW(2), .HOLD_CYCLES(H)) u_pwr_off_ctl (
    .clk(clk), .rst_n(rst_n), .btn_raw(btn_raw), .btn_irq(btn_irq),
    .glitch(glitch), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .pwr_off_n(pwr_off_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic bi_next(logic cur, logic irq, logic clr);
    return irq | (cur & ~clr);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; btn_raw = 0; btn_irq = 0; glitch = 0; wr_en = 0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  initial begin
    logic [7:0] v;
    logic       exp_bi;
    void'($urandom(32'd2024));
    do_reset();

    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd1, v); chk("R1 stat", v, 8'h00);
    chk("R1 pwr_off_n", {7'b0, pwr_off_n}, 8'h01);
    rd(2'd2, v); chk("R11 addr2", v, 8'h00);
    rd(2'd3, v); chk("R11 addr3", v, 8'h00);

    btn_raw = 1; tick();
    rd(2'd1, v); chk("R2 level after 1 edge", v, 8'h00);
    tick();
    rd(2'd1, v); chk("R2 level after 2 edges", v, 8'h01);
    btn_raw = 0; tick();
    rd(2'd1, v); chk("R2 level held", v, 8'h01);
    tick();
    rd(2'd1, v); chk("R2 level released", v, 8'h00);

    btn_raw = 1; repeat (H-1) tick();
    btn_raw = 0; repeat (4) tick();
    rd(2'd1, v); chk("R8 short press no flag", v, 8'h00);
    chk("R8 short press power", {7'b0, pwr_off_n}, 8'h01);

    btn_raw = 1; repeat (H) tick();
    btn_raw = 0; tick();
    rd(2'd1, v); chk("R7 spo not yet", v & 8'h04, 8'h00);
    tick();
    rd(2'd1, v); chk("R7 spo on time", v, 8'h04);
    chk("R7 no power-off without enable", {7'b0, pwr_off_n}, 8'h01);
    repeat (3) tick();

    wr(2'd1, 8'h04);
    rd(2'd1, v); chk("R4 clear spo", v, 8'h00);
    btn_raw = 1; repeat (H+2) tick();
    rd(2'd1, v); chk("R7 long hold sets spo", v & 8'h04, 8'h04);
    wr(2'd1, 8'h04);
    repeat (2*H) tick();
    rd(2'd1, v); chk("R7 once per press", v & 8'h04, 8'h00);
    btn_raw = 0; repeat (4) tick();

    btn_irq = 1; tick(); btn_irq = 0;
    rd(2'd1, v); chk("R3 irq sets flag", v, 8'h02);
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk("R4 write 0 keeps flag", v, 8'h02);
    btn_irq = 1; wr(2'd1, 8'h02); btn_irq = 0;
    rd(2'd1, v); chk("R4 set beats clear", v, 8'h02);
    wr(2'd1, 8'h02);
    rd(2'd1, v); chk("R4 clear bi", v, 8'h00);

    wr(2'd0, 8'h02);
    rd(2'd0, v); chk("R6 turn-off ignored", v, 8'h00);
    rd(2'd1, v); chk("R6 no flags", v, 8'h00);
    chk("R6 power stays", {7'b0, pwr_off_n}, 8'h01);

    glitch = 1; tick(); glitch = 0;
    rd(2'd1, v); chk("R9 glitch disabled no eo", v, 8'h00);
    chk("R9 glitch disabled power", {7'b0, pwr_off_n}, 8'h01);

    exp_bi = 1'b0;
    addr = 2'd1;
    for (int i = 0; i < 300; i++) begin
      logic irq, w;
      logic [7:0] d;
      irq = ($urandom % 3) == 0;
      w = $urandom % 2;
      d = 8'($urandom);
      btn_irq = irq; wr_en = w; addr = 2'd1; wr_data = d;
      exp_bi = bi_next(exp_bi, irq, w & d[1]);
      tick();
      btn_irq = 0; wr_en = 0;
      rd(2'd1, v); chk("R3/R4 random bi", {7'b0, v[1]}, {7'b0, exp_bi});
    end
    chk("R6 random phase power", {7'b0, pwr_off_n}, 8'h01);

    do_reset();
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h03);
    chk("R5 power off", {7'b0, pwr_off_n}, 8'h00);
    rd(2'd0, v); chk("R5 ctrl readback", v, 8'h03);
    rd(2'd1, v); chk("R5 spo and eo", v, 8'h0C);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h0F);
    repeat (3) tick();
    rd(2'd1, v); chk("R10 flags cleared", v, 8'h00);
    chk("R10 power stays off", {7'b0, pwr_off_n}, 8'h00);

    do_reset();
    chk("R1 reset restores power", {7'b0, pwr_off_n}, 8'h01);
    wr(2'd0, 8'h04);
    glitch = 1; tick(); glitch = 0;
    chk("R9 glitch enabled off", {7'b0, pwr_off_n}, 8'h00);
    rd(2'd1, v); chk("R9 eo only", v, 8'h08);

    do_reset();
    wr(2'd0, 8'h01);
    btn_raw = 1; repeat (H+1) tick();
    chk("R7 power before fire", {7'b0, pwr_off_n}, 8'h01);
    tick();
    chk("R7 long press off", {7'b0, pwr_off_n}, 8'h00);
    rd(2'd1, v); chk("R7 long press flags", v, 8'h0D);
    btn_raw = 0; repeat (3) tick();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule